// File: doc/BRIEF.md
# ADC Freeze and Low-Power Stop Controller

This block governs when a simple conversion sequencer may run. A 16-bit configuration register holds a low-power stop flag, a two-bit response code for the debug freeze input, and a supervisor flag that has no effect on behaviour. When the stop flag is set, any running conversion is cancelled. When the flag is cleared, the block waits out a fixed settling interval before it allows conversions again.

While the debug freeze input is high, the response code selects one of three behaviours. The block can ignore the input. It can let the current conversion finish and then hold at the boundary. Or it can hold at once and keep the partial progress, so that work resumes from that point.

The sequencer is part of the block. It is a counter that spends a parameter-set number of cycles on each conversion, with one idle cycle between conversions. The busy, done and progress signals of that counter are brought out so that the freeze and stop behaviour can be seen.

Top module: `adc_halt_ctrl`

## Requirements
- R1: After reset the register reads 16'h8080 (stop=1, freeze code=00, supervisor=1), abort is high, and ready, start_en, conv_busy and conv_done are low.
- R2: The register reads back as {stop at bit 15, freeze code at bits 14:13, supervisor at bit 7}. All other bits read 0, and a write takes effect on the next cycle.
- R3: A write with bit 15 set raises abort in the same cycle. The sequencer is then idle with progress 0 after that clock edge.
- R4: After the stop flag is cleared, ready and start_en stay low for exactly REC_CYCLES clock cycles, and ready goes high on the next one.
- R5: Freeze codes 00 and 01 ignore the freeze input: halt stays low and conversions keep running.
- R6: With freeze code 10 and freeze high, a running conversion completes and pulses conv_done. halt then goes high and no new conversion starts.
- R7: With freeze code 11 and freeze high, halt goes high at once and conv_busy and conv_progress hold their values.
- R8: When freeze drops, or the code changes to 00, sequencing continues on the next clock edge from the state it held.
- R9: The supervisor bit is stored and read back but changes no output other than the read data.
- R10: A conversion keeps conv_busy high for CONV_CYCLES cycles while conv_progress counts 0 upward. conv_done then pulses for one cycle while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register read data |
| freeze_i | input | 1 | Debug freeze request |
| start_en | output | 1 | Sequencer may begin a conversion |
| abort | output | 1 | Cancel any conversion in progress |
| halt | output | 1 | Sequencer is held by the freeze response |
| ready | output | 1 | Settling interval after stop has elapsed |
| conv_busy | output | 1 | A conversion is in progress |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |
| conv_progress | output | CONV_W | Cycle index inside the current conversion |

## Verification
The assertions check on every cycle that abort leaves the sequencer idle and that a hold keeps busy and progress unchanged. They also check that a finish-then-halt never halts in the middle of a conversion, that freeze codes 00 and 01 never slow a running conversion, that done never pulses twice in a row, and that register writes read back masked. Only the bench scenarios can show the exact length of the settling interval, resumption from the saved progress after freeze drops, and that the supervisor flag leaves every output unchanged. These are checked against a cycle model of the requirements under random register writes and freeze toggling.

// File: rtl/adchc_pkg.sv
package adchc_pkg;
  localparam int STOP_BIT = 15;
  localparam int FRZ_HI   = 14;
  localparam int FRZ_LO   = 13;
  localparam int SUPV_BIT = 7;
  localparam logic [15:0] RD_MASK = 16'hE080;

  typedef enum logic [1:0] {
    FRZ_IGNORE = 2'b00,
    FRZ_RSVD   = 2'b01,
    FRZ_FINISH = 2'b10,
    FRZ_NOW    = 2'b11
  } frz_mode_e;
endpackage

// File: rtl/adchc_cfg_reg.sv
module adchc_cfg_reg
  import adchc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        stop,
  output frz_mode_e   frz,
  output logic        supv
);
  logic      stop_q, stop_d;
  frz_mode_e frz_q, frz_d;
  logic      supv_q, supv_d;

  always_comb begin
    stop_d = wdata[STOP_BIT];
    frz_d  = frz_mode_e'(wdata[FRZ_HI:FRZ_LO]);
    supv_d = wdata[SUPV_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      frz_q  <= FRZ_IGNORE;
      supv_q <= 1'b1;
    end else if (wr_en) begin
      stop_q <= stop_d;
      frz_q  <= frz_d;
      supv_q <= supv_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[STOP_BIT] = stop_q;
    rdata[FRZ_HI:FRZ_LO] = frz_q;
    rdata[SUPV_BIT] = supv_q;
  end

  assign stop = stop_q;
  assign frz  = frz_q;
  assign supv = supv_q;

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wdata) & RD_MASK));
endmodule

// File: rtl/adchc_recovery.sv
module adchc_recovery #(
  parameter int REC_CYCLES = 20,
  localparam int REC_W = $clog2(REC_CYCLES + 1) < 1 ? 1 : $clog2(REC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  output logic ready
);
  logic [REC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (stop)            cnt_d = REC_W'(REC_CYCLES);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= REC_W'(REC_CYCLES);
    else        cnt_q <= cnt_d;
  end

  assign ready = !stop && (cnt_q == 0);

  assert_stop_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (cnt_q == REC_W'(REC_CYCLES)));
endmodule

// File: rtl/adchc_conv_seq.sv
module adchc_conv_seq #(
  parameter int CONV_CYCLES = 8,
  localparam int CONV_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              hold,
  input  logic              start_en,
  output logic              busy,
  output logic              done,
  output logic [CONV_W-1:0] progress
);
  localparam logic [CONV_W-1:0] LAST = CONV_W'(CONV_CYCLES - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CONV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (hold) begin
      busy_d = busy_q;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start_en) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign progress = cnt_q;

  assert_abort_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && progress == '0));
  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !abort) |=> ($stable(progress) && $stable(busy)));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !$past(done)));
endmodule

// File: rtl/adc_halt_ctrl.sv
module adc_halt_ctrl
  import adchc_pkg::*;
#(
  parameter int REC_CYCLES  = 20,
  parameter int CONV_CYCLES = 8,
  localparam int CONV_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              freeze_i,
  output logic              start_en,
  output logic              abort,
  output logic              halt,
  output logic              ready,
  output logic              conv_busy,
  output logic              conv_done,
  output logic [CONV_W-1:0] conv_progress
);
  localparam logic [CONV_W-1:0] LAST = CONV_W'(CONV_CYCLES - 1);

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic      stop_q, supv_q;
  frz_mode_e frz_q;

  adchc_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .stop  (stop_q),
    .frz   (frz_q),
    .supv  (supv_q)
  );

  adchc_recovery #(.REC_CYCLES(REC_CYCLES)) u_rec (
    .clk   (clk),
    .rst_n (rst_sync),
    .stop  (stop_q),
    .ready (ready)
  );

  logic halt_now, halt_fin;
  always_comb begin
    abort    = stop_q || (reg_wr && reg_wdata[STOP_BIT]);
    halt_now = freeze_i && (frz_q == FRZ_NOW);
    halt_fin = freeze_i && (frz_q == FRZ_FINISH) && !conv_busy;
    halt     = halt_now || halt_fin;
    start_en = ready && !halt;
  end

  adchc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .abort    (abort),
    .hold     (halt),
    .start_en (start_en),
    .busy     (conv_busy),
    .done     (conv_done),
    .progress (conv_progress)
  );

  assert_fin_boundary_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (halt && frz_q != FRZ_NOW) |-> !conv_busy);
  assert_ignore_runs_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (!frz_q[1] && !abort && conv_busy && conv_progress != LAST)
      |=> conv_progress == $past(conv_progress) + 1'b1);
  assert_no_start_unready_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    !ready |=> !$rose(conv_busy));
endmodule

// File: tb/adc_halt_ctrl_tb.sv
`timescale 1ns/1ps
module adc_halt_ctrl_tb;
  localparam int REC  = 20;
  localparam int CONV = 8;
  localparam int CW   = $clog2(CONV);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic          freeze_i = 1'b0;
  logic [15:0]   reg_rdata;
  logic          start_en, abort, halt, ready, conv_busy, conv_done;
  logic [CW-1:0] conv_progress;

  int n_vec = 0;
  int n_bad = 0;
  string dir_tag = "";

  always #4 clk = ~clk;

  adc_halt_ctrl #(.REC_CYCLES(REC), .CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .freeze_i(freeze_i), .start_en(start_en),
    .abort(abort), .halt(halt), .ready(ready), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_progress(conv_progress)
  );

  // requirement model state
  logic     m_stop, m_supv, m_busy, m_done;
  logic [1:0] m_frz;
  int       m_rec, m_cnt;

  function automatic logic [15:0] exp_rdata();
    return {m_stop, m_frz, 5'b0, m_supv, 7'b0};
  endfunction
  function automatic logic exp_ready();
    return !m_stop && m_rec == 0;
  endfunction
  function automatic logic exp_halt(input logic frzin);
    return frzin && (m_frz == 2'b11 || (m_frz == 2'b10 && !m_busy));
  endfunction

  task automatic chk(input string tag, input string name,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t",
               (dir_tag != "") ? dir_tag : tag, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_stop = 1'b1; m_frz = 2'b00; m_supv = 1'b1;
    m_rec = REC; m_busy = 1'b0; m_cnt = 0; m_done = 1'b0;
  endtask

  task automatic step(input logic wr, input logic [15:0] wd, input logic frzin);
    logic e_abort, e_halt, e_start;
    string htag;
    reg_wr = wr; reg_wdata = wd; freeze_i = frzin;
    #1;
    e_abort = m_stop || (wr && wd[15]);
    e_halt  = exp_halt(frzin);
    e_start = exp_ready() && !e_halt;
    htag = (m_frz == 2'b11) ? "R7" : (m_frz == 2'b10) ? "R6" : "R5";
    chk("R2", "rdata", reg_rdata, exp_rdata());
    chk("R3", "abort", 16'(abort), 16'(e_abort));
    chk("R4", "ready", 16'(ready), 16'(exp_ready()));
    chk("R4", "start_en", 16'(start_en), 16'(e_start));
    chk(htag, "halt", 16'(halt), 16'(e_halt));
    chk("R10", "busy", 16'(conv_busy), 16'(m_busy));
    chk("R10", "done", 16'(conv_done), 16'(m_done));
    chk(htag, "progress", 16'(conv_progress), 16'(m_cnt));
    @(posedge clk);
    if (m_stop) m_rec = REC; else if (m_rec != 0) m_rec--;
    if (e_abort) begin
      m_busy = 1'b0; m_cnt = 0; m_done = 1'b0;
    end else if (e_halt) begin
      m_done = 1'b0;
    end else if (m_busy) begin
      if (m_cnt == CONV - 1) begin m_busy = 1'b0; m_cnt = 0; m_done = 1'b1; end
      else begin m_cnt++; m_done = 1'b0; end
    end else begin
      m_done = 1'b0;
      if (e_start) begin m_busy = 1'b1; m_cnt = 0; end
    end
    if (wr) begin m_stop = wd[15]; m_frz = wd[14:13]; m_supv = wd[7]; end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int unused_seed;
    logic fz;
    logic [CW-1:0] held;
    unused_seed = $urandom(32'h5eed_0c1a);
    model_reset();
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    dir_tag = "R1";
    chk("R1", "rst_rdata", reg_rdata, 16'h8080);
    chk("R1", "rst_abort", 16'(abort), 16'h1);
    chk("R1", "rst_ready", 16'(ready), 16'h0);
    step(1'b0, 16'h0, 1'b0);

    // R2 unused bits read zero
    dir_tag = "R2";
    step(1'b1, 16'hFFFF, 1'b0);
    chk("R2", "mask", reg_rdata, 16'hE080);

    // R4 settling interval then R10 conversions, code 00
    dir_tag = "R4";
    step(1'b1, 16'h0000, 1'b0);
    for (int i = 0; i < REC; i++) step(1'b0, 16'h0, 1'b0);
    chk("R4", "ready_after_wait", 16'(ready), 16'h1);
    dir_tag = "R10";
    for (int i = 0; i < 2 * CONV + 4; i++) step(1'b0, 16'h0, 1'b0);

    // R7 immediate hold, then R8 resume
    dir_tag = "R7";
    step(1'b1, 16'h6000, 1'b0);
    while (!(conv_busy && conv_progress == 3)) step(1'b0, 16'h0, 1'b0);
    held = conv_progress;
    for (int i = 0; i < 5; i++) step(1'b0, 16'h0, 1'b1);
    chk("R7", "held_progress", 16'(conv_progress), 16'(held));
    dir_tag = "R8";
    step(1'b0, 16'h0, 1'b0);
    chk("R8", "resume_progress", 16'(conv_progress), 16'(held + 1'b1));

    // R6 finish then halt, then R8 via code change to 00
    dir_tag = "R6";
    step(1'b1, 16'h4000, 1'b0);
    while (!(conv_busy && conv_progress == 2)) step(1'b0, 16'h0, 1'b0);
    for (int i = 0; i < CONV + 4; i++) step(1'b0, 16'h0, 1'b1);
    chk("R6", "idle_halted", 16'({conv_busy, halt}), 16'b01);
    dir_tag = "R8";
    step(1'b1, 16'h0000, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b1);

    // R5 reserved code ignores freeze
    dir_tag = "R5";
    step(1'b1, 16'h2000, 1'b1);
    for (int i = 0; i < CONV + 3; i++) step(1'b0, 16'h0, 1'b1);

    // R9 supervisor flag toggled while running
    dir_tag = "R9";
    step(1'b1, 16'h0080, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0);
    step(1'b1, 16'h0000, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0);

    // R3 stop during a conversion
    dir_tag = "R3";
    while (!conv_busy) step(1'b0, 16'h0, 1'b0);
    step(1'b1, 16'h8000, 1'b0);
    chk("R3", "busy_after_stop", 16'(conv_busy), 16'h0);

    // constrained random
    dir_tag = "";
    fz = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [15:0] wd;
      wr = ($urandom % 12) == 0;
      wd = 16'($urandom);
      wd[15] = ($urandom % 5) == 0;
      if (($urandom % 9) == 0) fz = ~fz;
      step(wr, wd, fz);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule